// File: doc/BRIEF.md
# DMA Channel Request Qualifier

This block decides which DMA channel may move its next data element. Each cycle it checks every channel's configuration word against the controller's global enable and the peripheral request lines. It then picks the lowest-numbered channel that qualifies. The choice goes into a register and is offered to the transfer engine as a grant. The grant stays fixed until the engine reports that the element has moved. Only after that report does the block scan the channels again.

A channel's configuration word holds several fields. One is a flow field that says which peripheral requests must be active before the channel may run: none, the destination's, the source's, or both. Two 5-bit fields name the source and destination peripherals. The request lines are two 16-bit vectors, one for single requests and one for burst requests. The block treats a peripheral as requesting when its bit is set in either vector. Flow codes that need the peripheral to control the flow are not supported. The block flags such channels and never grants them.

Top module: `dma_req_qualifier`

## Requirements
- R1: While `glob_en_i` is 0, no new grant is issued: an idle `grant_vld_o` stays 0.
- R2: A channel can qualify only when bit 0 of its configuration word (enable) is 1 and bit 18 (halt) is 0.
- R3: In each configuration word, bits [13:11] hold the flow code, bits [5:1] the source peripheral ID and bits [10:6] the destination peripheral ID. A peripheral counts as requesting when its bit is set in `req_single_i` OR in `req_burst_i`. IDs 16 to 31 never count as requesting.
- R4: Flow code 0 lets a channel qualify with no request active.
- R5: Flow code 1 needs the destination ID's request. Flow code 2 needs the source ID's request. Flow code 3 needs both.
- R6: For an enabled, unhalted channel with a flow code of 4 to 7, bit c of `unsup_o` is set in the same cycle. That channel is never granted.
- R7: When several channels qualify, the one with the lowest index is granted.
- R8: Timing of the grant:
  - The grant is registered. `grant_vld_o` rises on the clock edge after a channel qualifies.
  - While `elem_done_i` is 0, `grant_vld_o` stays 1 and `grant_ch_o` keeps its value, even if other channels qualify.
- R9: On the edge where `elem_done_i` is 1 during a grant, `grant_vld_o` falls. The channels are scanned again on the following edge.
- R10: After reset, `grant_vld_o` is 0 and `grant_ch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Global controller enable |
| ch_cfg_i | input | NUM_CH*32 | Per-channel configuration words, channel c at bits [32c+31:32c] |
| req_single_i | input | 16 | Single-request lines by peripheral ID |
| req_burst_i | input | 16 | Burst-request lines by peripheral ID |
| elem_done_i | input | 1 | Engine has moved the granted element |
| grant_vld_o | output | 1 | A channel is granted |
| grant_ch_o | output | $clog2(NUM_CH) | Index of the granted channel |
| unsup_o | output | NUM_CH | Per-channel flag for an unsupported flow code |

## Verification
The hardest case to reach is a lower-numbered channel becoming eligible while a higher-numbered channel already holds the grant. In that case the priority pick must be ignored until the engine reports done. The stimulus grants channel 3 first and then enables channel 1 while the grant is held. It checks that channel 3 stays on the output for several cycles. It then pulses done and expects channel 1 to win the next scan. A second hard case is an unsupported channel at index 0 next to a plain one at index 1: the grant must skip channel 0.

// File: rtl/dma_qual_pkg.sv
package dma_qual_pkg;
  localparam int CFG_W    = 32;
  localparam int REQ_W    = 16;
  localparam int ID_W     = 5;
  localparam int FLOW_W   = 3;
  localparam int EN_BIT   = 0;
  localparam int SRC_LSB  = 1;
  localparam int DST_LSB  = 6;
  localparam int FLOW_LSB = 11;
  localparam int HALT_BIT = 18;

  typedef enum logic [FLOW_W-1:0] {
    FLOW_FREE  = 3'd0,
    FLOW_DST   = 3'd1,
    FLOW_SRC   = 3'd2,
    FLOW_BOTH  = 3'd3,
    FLOW_PER4  = 3'd4,
    FLOW_PER5  = 3'd5,
    FLOW_PER6  = 3'd6,
    FLOW_PER7  = 3'd7
  } flow_e;
endpackage

// File: rtl/dma_ch_eligible.sv
module dma_ch_eligible
  import dma_qual_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [REQ_W-1:0] req_set_i,
  input  logic             glob_en_i,
  output logic             elig_o,
  output logic             unsup_o
);
  localparam int ID_SPAN = 1 << ID_W;

  logic [ID_SPAN-1:0] req_ext;
  logic [ID_W-1:0]    src_id, dst_id;
  flow_e              flow;
  logic               live, src_hit, dst_hit, flow_ok;
  logic               unused_cfg;

  assign unused_cfg = ^{cfg_i[CFG_W-1:HALT_BIT+1], cfg_i[HALT_BIT-1:FLOW_LSB+FLOW_W]};

  assign req_ext = ID_SPAN'(req_set_i);
  assign src_id  = cfg_i[SRC_LSB +: ID_W];
  assign dst_id  = cfg_i[DST_LSB +: ID_W];
  assign flow    = flow_e'(cfg_i[FLOW_LSB +: FLOW_W]);
  assign live    = cfg_i[EN_BIT] & ~cfg_i[HALT_BIT];
  assign src_hit = req_ext[src_id];
  assign dst_hit = req_ext[dst_id];

  always_comb begin
    case (flow)
      FLOW_FREE: flow_ok = 1'b1;
      FLOW_DST:  flow_ok = dst_hit;
      FLOW_SRC:  flow_ok = src_hit;
      FLOW_BOTH: flow_ok = src_hit & dst_hit;
      default:   flow_ok = 1'b0;
    endcase
  end

  assign elig_o  = glob_en_i & live & flow_ok;
  assign unsup_o = live & flow[FLOW_W-1];
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (elig_i[c]) idx_o = IDX_W'(c);
    end
  end

  assign any_o = |elig_i;
endmodule

// File: rtl/dma_req_qualifier.sv
module dma_req_qualifier
  import dma_qual_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glob_en_i,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg_i,
  input  logic [REQ_W-1:0]        req_single_i,
  input  logic [REQ_W-1:0]        req_burst_i,
  input  logic                    elem_done_i,
  output logic                    grant_vld_o,
  output logic [IDX_W-1:0]        grant_ch_o,
  output logic [NUM_CH-1:0]       unsup_o
);
  logic [REQ_W-1:0]  req_set;
  logic [NUM_CH-1:0] elig;
  logic              any_elig;
  logic [IDX_W-1:0]  pick_idx;
  logic              vld_q, vld_d, load_en;
  logic [IDX_W-1:0]  ch_q, ch_d;

  assign req_set = req_single_i | req_burst_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_ch_eligible u_elig (
      .cfg_i     (ch_cfg_i[c*CFG_W +: CFG_W]),
      .req_set_i (req_set),
      .glob_en_i (glob_en_i),
      .elig_o    (elig[c]),
      .unsup_o   (unsup_o[c])
    );
  end

  dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig_i (elig),
    .any_o  (any_elig),
    .idx_o  (pick_idx)
  );

  always_comb begin
    if (!vld_q) begin
      load_en = any_elig;
      vld_d   = any_elig;
      ch_d    = pick_idx;
    end else begin
      load_en = elem_done_i;
      vld_d   = 1'b0;
      ch_d    = ch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
    end else if (load_en) begin
      vld_q <= vld_d;
      ch_q  <= ch_d;
    end
  end

  assign grant_vld_o = vld_q;
  assign grant_ch_o  = ch_q;
endmodule

// File: rtl/dma_req_qualifier_chk.sv
module dma_req_qualifier_chk #(
  parameter int NUM_CH = 8,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en_i,
  input logic              elem_done_i,
  input logic              grant_vld_o,
  input logic [IDX_W-1:0]  grant_ch_o,
  input logic [NUM_CH-1:0] unsup_o
);
  logic [NUM_CH-1:0] gsel;
  assign gsel = NUM_CH'(1) << grant_ch_o;

  a_r1_off_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en_i && !grant_vld_o) |=> !grant_vld_o);

  a_r1_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld_o) |-> $past(glob_en_i));

  a_r6_unsup_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld_o) |-> (($past(unsup_o) & gsel) == '0));

  a_r8_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && !elem_done_i) |=> (grant_vld_o && $stable(grant_ch_o)));

  a_r9_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld_o && elem_done_i) |=> !grant_vld_o);
endmodule

bind dma_req_qualifier dma_req_qualifier_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glob_en_i   (glob_en_i),
  .elem_done_i (elem_done_i),
  .grant_vld_o (grant_vld_o),
  .grant_ch_o  (grant_ch_o),
  .unsup_o     (unsup_o)
);

// File: tb/tb_dma_req_qualifier.sv
module tb_dma_req_qualifier;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 8;
  localparam int IDX_W      = $clog2(NUM_CH);

  logic                 clk, rst_n, glob_en, done;
  logic [NUM_CH*32-1:0] cfg;
  logic [15:0]          rs, rb;
  logic                 vld;
  logic [IDX_W-1:0]     gch;
  logic [NUM_CH-1:0]    unsup;
  int                   n_chk, n_err;
  bit                   finished;

  dma_req_qualifier #(.NUM_CH(NUM_CH)) dut (
    .clk(clk), .rst_n(rst_n), .glob_en_i(glob_en), .ch_cfg_i(cfg),
    .req_single_i(rs), .req_burst_i(rb), .elem_done_i(done),
    .grant_vld_o(vld), .grant_ch_o(gch), .unsup_o(unsup)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(bit en, bit halt, int flow, int src, int dst);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[18] = halt;
    w[13:11] = 3'(flow); w[5:1] = 5'(src); w[10:6] = 5'(dst);
    return w;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_grant(string req, bit ev, int ec);
    chk(vld == ev, {req, " vld"}, int'(vld), int'(ev));
    if (ev) chk(int'(gch) == ec, {req, " ch"}, int'(gch), ec);
  endtask

  task automatic clear_all();
    cfg = '0; rs = '0; rb = '0; glob_en = 1'b1;
    done = 1'b1; tick(); done = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk(vld == 1'b0, "R10 vld", int'(vld), 0);
    chk(gch == '0, "R10 ch", int'(gch), 0);
  endtask

  task automatic t_global();
    cfg[0 +: 32] = mk(1, 0, 0, 0, 0); glob_en = 1'b0;
    tick(); tick();
    chk_grant("R1 disabled", 0, 0);
    glob_en = 1'b1; tick();
    chk_grant("R4 flow0 granted", 1, 0);
    clear_all();
  endtask

  task automatic t_done();
    cfg[0 +: 32] = mk(1, 0, 0, 0, 0); tick();
    chk_grant("R8 grant", 1, 0);
    done = 1'b1; tick(); done = 1'b0;
    chk_grant("R9 drop", 0, 0);
    tick();
    chk_grant("R9 rescan", 1, 0);
    clear_all();
  endtask

  task automatic t_enable_halt();
    cfg[0 +: 32] = mk(1, 1, 0, 0, 0); tick(); tick();
    chk_grant("R2 halted", 0, 0);
    cfg[0 +: 32] = mk(0, 0, 0, 0, 0); tick(); tick();
    chk_grant("R2 disabled ch", 0, 0);
    clear_all();
  endtask

  task automatic t_flows();
    cfg[1*32 +: 32] = mk(1, 0, 1, 9, 5); tick(); tick();
    chk_grant("R5 flow1 no req", 0, 0);
    rs[9] = 1'b1; tick(); tick();
    chk_grant("R5 flow1 src only", 0, 0);
    rs[5] = 1'b1; tick();
    chk_grant("R5 flow1 dst single", 1, 1);
    clear_all();
    cfg[2*32 +: 32] = mk(1, 0, 2, 9, 5); rb[9] = 1'b1; tick();
    chk_grant("R3 flow2 src burst", 1, 2);
    clear_all();
    cfg[4*32 +: 32] = mk(1, 0, 3, 3, 7); rs[3] = 1'b1; tick(); tick();
    chk_grant("R5 flow3 one req", 0, 0);
    rb[7] = 1'b1; tick();
    chk_grant("R5 flow3 both", 1, 4);
    clear_all();
    cfg[0 +: 32] = mk(1, 0, 2, 20, 0); rs = '1; rb = '1; tick(); tick();
    chk_grant("R3 id above 15", 0, 0);
    clear_all();
  endtask

  task automatic t_unsup();
    cfg[0 +: 32] = mk(1, 0, 5, 0, 0); cfg[1*32 +: 32] = mk(1, 0, 0, 0, 0);
    rs = '1; tick();
    chk(unsup == 8'b0000_0001, "R6 flag", int'(unsup), 1);
    chk_grant("R6 skip unsup", 1, 1);
    clear_all();
  endtask

  task automatic t_prio();
    cfg[3*32 +: 32] = mk(1, 0, 0, 0, 0);
    cfg[5*32 +: 32] = mk(1, 0, 0, 0, 0);
    cfg[6*32 +: 32] = mk(1, 0, 0, 0, 0); tick();
    chk_grant("R7 lowest", 1, 3);
    cfg[1*32 +: 32] = mk(1, 0, 0, 0, 0); tick(); tick(); tick();
    chk_grant("R8 held", 1, 3);
    done = 1'b1; tick(); done = 1'b0; tick();
    chk_grant("R7 rescan lowest", 1, 1);
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; finished = 0;
    rst_n = 1'b0; glob_en = 1'b0; done = 1'b0;
    cfg = '0; rs = '0; rb = '0;
    tick(); tick();
    t_reset();
    rst_n = 1'b1; tick();
    t_global();
    t_done();
    t_enable_halt();
    t_flows();
    t_unsup();
    t_prio();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule